// File: doc/BRIEF.md
# Low-Power Mode Controller

This block sequences the idle and power-down states of a small microcontroller. Software selects a state by writing two request bits. Bit 0 asks for idle and bit 1 asks for power-down. If both bits are set, power-down wins. In idle, the CPU clock enable falls while the peripheral clock and the oscillator stay on. In power-down, all three enables fall, so the oscillator, the peripherals and the CPU all stop.

Idle ends when any enabled interrupt is pending or when the hardware reset line is high. Power-down ends only in two cases: the hardware reset line is high, or an external interrupt line is high while the wake enable input is set. That input mirrors bit 3 of the auxiliary control register.

When power-down ends, the oscillator enable rises first. A settle counter, loaded from a programmable count, must then expire while the wake source stays active. Only after that do the clocks return. If the wake source drops before the counter expires, the block falls back into power-down.

Every exit pulses one of two outputs:
- `restart_o` tells the CPU to restart and reinitialise its special function registers.
- `resume_irq_o` tells the CPU to continue at the interrupt service routine with all state kept.

The request bits clear on every exit.

Top module: `lpm_ctrl`

## Requirements
- R1: After rst_ni is released, ctrl_bits_o is 00, cpu_clk_en_o, periph_clk_en_o and osc_en_o are 1, and resume_irq_o and restart_o are 0.
- R2: In the run state, a write with pcon_wdata_i = 01 (bit 0 idle, bit 1 power-down) takes effect one cycle after the write: ctrl_bits_o reads 01, cpu_clk_en_o is 0, and periph_clk_en_o and osc_en_o stay 1.
- R3: In the run state, a write with bit 1 set enters power-down whatever bit 0 holds: on the next cycle cpu_clk_en_o, periph_clk_en_o and osc_en_o are all 0 and ctrl_bits_o shows the written value.
- R4: In idle, any set bit of irq_pend_i returns the block to run on the next cycle: ctrl_bits_o is 00, all enables are 1, and resume_irq_o is high for exactly one cycle.
- R5: A high hw_rst_i ends idle on the next cycle. It also ends power-down once the settle count has expired. Either exit gives a one-cycle restart_o pulse, clears ctrl_bits_o, and leaves resume_irq_o low. When reset and an interrupt arrive together, restart_o is the one that pulses.
- R6: In power-down, an external interrupt has no effect while wake_en_i is 0: all enables stay 0.
- R7: In power-down, with wake_en_i = 1, a high ext_irq_i line raises osc_en_o on the next cycle. cpu_clk_en_o and periph_clk_en_o stay 0 for settle_cycles_i + 1 cycles. They then rise together with a one-cycle resume_irq_o pulse and ctrl_bits_o = 00.
- R8: If the wake source goes low while the settle count is running, osc_en_o returns to 0 on the next cycle with no exit pulse and the request bits kept.
- R9: irq_pend_i does not wake the block from power-down.
- R10: Writes to the request bits are ignored while the block is in idle or power-down.
- R11: cpu_clk_en_o is never 1 while osc_en_o is 0, and resume_irq_o and restart_o are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Always-on controller clock |
| rst_ni | input | 1 | Asynchronous active-low power-on reset |
| pcon_wr_i | input | 1 | Write strobe for the request bits |
| pcon_wdata_i | input | 2 | Request data: bit 0 idle, bit 1 power-down |
| hw_rst_i | input | 1 | Hardware reset request (wake and restart source) |
| irq_pend_i | input | N_IRQ | Enabled, pending interrupt lines |
| ext_irq_i | input | N_EXT | External interrupt lines |
| wake_en_i | input | 1 | Wake-from-power-down enable (auxiliary control bit 3) |
| settle_cycles_i | input | CNT_W | Oscillator settle count |
| ctrl_bits_o | output | 2 | Current request bits |
| cpu_clk_en_o | output | 1 | CPU clock enable |
| periph_clk_en_o | output | 1 | Peripheral clock enable |
| osc_en_o | output | 1 | Oscillator enable |
| resume_irq_o | output | 1 | One-cycle pulse: resume at interrupt service routine |
| restart_o | output | 1 | One-cycle pulse: restart, reinitialise registers |

## Verification
Idle is tried with a single pending interrupt bit and with reset and an interrupt arriving together. This separates the resume exit from the restart exit and shows which one has priority.

Power-down is tried with these stimuli:
- interrupt-pending lines alone;
- an external line with the enable clear and every other stimulus quiet;
- an external line with the enable set that is dropped partway through the settle count;
- a held external line;
- a held reset.

Together these show that only qualified sources wake the block, that an aborted settle returns to power-down, and which exit pulse each source produces. Settle counts of 3 and 0 confirm that the clock release comes exactly count + 1 cycles after the oscillator restarts. Writes made during idle confirm that the request bits stay frozen.

// File: rtl/lpm_pkg.sv
package lpm_pkg;
  localparam int IDLE_BIT = 0;
  localparam int PD_BIT   = 1;

  typedef enum logic [1:0] {
    LP_RUN    = 2'd0,
    LP_IDLE   = 2'd1,
    LP_DOWN   = 2'd2,
    LP_SETTLE = 2'd3
  } lp_state_e;

  typedef struct packed {
    logic cpu_en;
    logic per_en;
    logic osc_en;
  } clk_en_t;

  function automatic clk_en_t decode_clk(lp_state_e s);
    clk_en_t c;
    c.cpu_en = (s == LP_RUN);
    c.per_en = (s == LP_RUN) || (s == LP_IDLE);
    c.osc_en = (s != LP_DOWN);
    return c;
  endfunction
endpackage

// File: rtl/lpm_req_reg.sv
module lpm_req_reg (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  input  logic       clr_i,
  output logic [1:0] bits_o
);
  logic [1:0] bits_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     bits_q <= '0;
    else if (clr_i)  bits_q <= '0;
    else if (wr_i)   bits_q <= wdata_i;
  end

  assign bits_o = bits_q;
endmodule

// File: rtl/lpm_wake_qual.sv
module lpm_wake_qual #(
  parameter int N_IRQ    = 8,
  parameter int N_EXT    = 2,
  parameter bit EXT_SYNC = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [N_IRQ-1:0] irq_pend_i,
  input  logic [N_EXT-1:0] ext_irq_i,
  input  logic             wake_en_i,
  input  logic             hw_rst_i,
  output logic             idle_wake_o,
  output logic             pd_src_o
);
  logic [N_EXT-1:0] ext_q;

  generate
    if (EXT_SYNC) begin : g_sync
      logic [N_EXT-1:0] s1_q, s2_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          s1_q <= '0;
          s2_q <= '0;
        end else begin
          s1_q <= ext_irq_i;
          s2_q <= s1_q;
        end
      end
      assign ext_q = s2_q;
    end else begin : g_direct
      logic unused_clk;
      assign unused_clk = clk_i ^ rst_ni;
      assign ext_q = ext_irq_i;
    end
  endgenerate

  // idle: any enabled pending interrupt; power-down: reset or qualified external line
  assign idle_wake_o = |irq_pend_i;
  assign pd_src_o    = hw_rst_i || (wake_en_i && (|ext_q));
endmodule

// File: rtl/lpm_settle_timer.sv
module lpm_settle_timer #(
  parameter int CNT_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             run_i,
  input  logic [CNT_W-1:0] load_val_i,
  output logic             done_o
);
  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= '0;
    else if (load_i)                cnt_q <= load_val_i;
    else if (run_i && cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
  end

  assign done_o = (cnt_q == '0);
endmodule

// File: rtl/lpm_fsm.sv
module lpm_fsm
  import lpm_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [1:0] wdata_i,
  input  logic       hw_rst_i,
  input  logic       idle_wake_i,
  input  logic       pd_src_i,
  input  logic       tmr_done_i,
  output lp_state_e  state_o,
  output logic       tmr_load_o,
  output logic       req_wr_o,
  output logic       req_clr_o,
  output logic       resume_o,
  output logic       restart_o
);
  lp_state_e state_q, state_d;
  logic resume_q, resume_d, restart_q, restart_d;

  always_comb begin
    state_d    = state_q;
    tmr_load_o = 1'b0;
    req_wr_o   = 1'b0;
    req_clr_o  = 1'b0;
    resume_d   = 1'b0;
    restart_d  = 1'b0;
    unique case (state_q)
      LP_RUN: begin
        if (wr_i && !hw_rst_i) begin
          req_wr_o = 1'b1;
          if (wdata_i[PD_BIT])        state_d = LP_DOWN;
          else if (wdata_i[IDLE_BIT]) state_d = LP_IDLE;
        end
      end
      LP_IDLE: begin
        if (hw_rst_i) begin
          state_d   = LP_RUN;
          req_clr_o = 1'b1;
          restart_d = 1'b1;
        end else if (idle_wake_i) begin
          state_d   = LP_RUN;
          req_clr_o = 1'b1;
          resume_d  = 1'b1;
        end
      end
      LP_DOWN: begin
        if (pd_src_i) begin
          state_d    = LP_SETTLE;
          tmr_load_o = 1'b1;
        end
      end
      LP_SETTLE: begin
        if (!pd_src_i) begin
          state_d = LP_DOWN;
        end else if (tmr_done_i) begin
          state_d   = LP_RUN;
          req_clr_o = 1'b1;
          restart_d = hw_rst_i;
          resume_d  = !hw_rst_i;
        end
      end
      default: state_d = LP_RUN;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= LP_RUN;
      resume_q  <= 1'b0;
      restart_q <= 1'b0;
    end else begin
      state_q   <= state_d;
      resume_q  <= resume_d;
      restart_q <= restart_d;
    end
  end

  assign state_o   = state_q;
  assign resume_o  = resume_q;
  assign restart_o = restart_q;
endmodule

// File: rtl/lpm_ctrl.sv
module lpm_ctrl
  import lpm_pkg::*;
#(
  parameter int N_IRQ    = 8,
  parameter int N_EXT    = 2,
  parameter int CNT_W    = 8,
  parameter bit EXT_SYNC = 1'b0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             pcon_wr_i,
  input  logic [1:0]       pcon_wdata_i,
  input  logic             hw_rst_i,
  input  logic [N_IRQ-1:0] irq_pend_i,
  input  logic [N_EXT-1:0] ext_irq_i,
  input  logic             wake_en_i,
  input  logic [CNT_W-1:0] settle_cycles_i,
  output logic [1:0]       ctrl_bits_o,
  output logic             cpu_clk_en_o,
  output logic             periph_clk_en_o,
  output logic             osc_en_o,
  output logic             resume_irq_o,
  output logic             restart_o
);
  lp_state_e state;
  clk_en_t   clk_en;
  logic idle_wake, pd_src, tmr_done, tmr_load, req_wr, req_clr;

  lpm_wake_qual #(.N_IRQ(N_IRQ), .N_EXT(N_EXT), .EXT_SYNC(EXT_SYNC)) u_wake (
    .clk_i(clk_i), .rst_ni(rst_ni), .irq_pend_i(irq_pend_i), .ext_irq_i(ext_irq_i),
    .wake_en_i(wake_en_i), .hw_rst_i(hw_rst_i),
    .idle_wake_o(idle_wake), .pd_src_o(pd_src)
  );

  lpm_fsm u_fsm (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(pcon_wr_i), .wdata_i(pcon_wdata_i),
    .hw_rst_i(hw_rst_i), .idle_wake_i(idle_wake), .pd_src_i(pd_src),
    .tmr_done_i(tmr_done), .state_o(state), .tmr_load_o(tmr_load),
    .req_wr_o(req_wr), .req_clr_o(req_clr),
    .resume_o(resume_irq_o), .restart_o(restart_o)
  );

  lpm_settle_timer #(.CNT_W(CNT_W)) u_timer (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tmr_load),
    .run_i(state == LP_SETTLE), .load_val_i(settle_cycles_i), .done_o(tmr_done)
  );

  lpm_req_reg u_req (
    .clk_i(clk_i), .rst_ni(rst_ni), .wr_i(req_wr), .wdata_i(pcon_wdata_i),
    .clr_i(req_clr), .bits_o(ctrl_bits_o)
  );

  assign clk_en          = decode_clk(state);
  assign cpu_clk_en_o    = clk_en.cpu_en;
  assign periph_clk_en_o = clk_en.per_en;
  assign osc_en_o        = clk_en.osc_en;
endmodule

// File: rtl/lpm_ctrl_chk.sv
module lpm_ctrl_chk #(
  parameter int N_EXT = 2
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             pcon_wr_i,
  input logic [1:0]       pcon_wdata_i,
  input logic             hw_rst_i,
  input logic [N_EXT-1:0] ext_irq_i,
  input logic             wake_en_i,
  input logic [1:0]       ctrl_bits_o,
  input logic             cpu_clk_en_o,
  input logic             osc_en_o,
  input logic             resume_irq_o,
  input logic             restart_o
);
  // R11
  cpu_needs_osc_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !osc_en_o |-> !cpu_clk_en_o);

  // R11
  exit_excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(resume_irq_o && restart_o));

  // R4
  resume_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    resume_irq_o |=> !resume_irq_o);

  // R5
  restart_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restart_o |=> !restart_o);

  // R6
  pd_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!osc_en_o && !hw_rst_i && !(wake_en_i && |ext_irq_i)) |=> !osc_en_o);

  // R7
  osc_first_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(osc_en_o) |-> !cpu_clk_en_o);

  // R3
  pd_prio_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pcon_wr_i && pcon_wdata_i[1] && cpu_clk_en_o && !hw_rst_i) |=> !osc_en_o);

  // R10
  bits_frozen_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !cpu_clk_en_o |=> (cpu_clk_en_o || ctrl_bits_o == $past(ctrl_bits_o)));
endmodule

bind lpm_ctrl lpm_ctrl_chk #(.N_EXT(N_EXT)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .pcon_wr_i(pcon_wr_i), .pcon_wdata_i(pcon_wdata_i),
  .hw_rst_i(hw_rst_i), .ext_irq_i(ext_irq_i), .wake_en_i(wake_en_i),
  .ctrl_bits_o(ctrl_bits_o), .cpu_clk_en_o(cpu_clk_en_o), .osc_en_o(osc_en_o),
  .resume_irq_o(resume_irq_o), .restart_o(restart_o)
);

// File: tb/lpm_ctrl_tb.sv
`timescale 1ns/100ps
module lpm_ctrl_tb;
  localparam int N_IRQ = 8;
  localparam int N_EXT = 2;
  localparam int CNT_W = 8;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic pcon_wr = 1'b0;
  logic [1:0] pcon_wdata = '0;
  logic hw_rst = 1'b0;
  logic [N_IRQ-1:0] irq_pend = '0;
  logic [N_EXT-1:0] ext_irq = '0;
  logic wake_en = 1'b0;
  logic [CNT_W-1:0] settle = 8'd3;
  logic [1:0] ctrl_bits;
  logic cpu_en, per_en, osc_en, resume, restart;

  always #2.5 clk = ~clk;

  lpm_ctrl #(.N_IRQ(N_IRQ), .N_EXT(N_EXT), .CNT_W(CNT_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .pcon_wr_i(pcon_wr), .pcon_wdata_i(pcon_wdata),
    .hw_rst_i(hw_rst), .irq_pend_i(irq_pend), .ext_irq_i(ext_irq), .wake_en_i(wake_en),
    .settle_cycles_i(settle), .ctrl_bits_o(ctrl_bits), .cpu_clk_en_o(cpu_en),
    .periph_clk_en_o(per_en), .osc_en_o(osc_en), .resume_irq_o(resume), .restart_o(restart)
  );

  typedef struct {
    int         due;
    logic [6:0] exp;
    string      req;
  } item_t;
  item_t sb_q[$];

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  always @(posedge clk) cyc <= cyc + 1;

  // {ctrl[1:0], cpu, per, osc, resume, restart}
  function automatic logic [6:0] ev(logic [1:0] c, logic cpu, logic per, logic osc,
                                    logic res, logic rst);
    return {c, cpu, per, osc, res, rst};
  endfunction

  // driver: push expectation for the cycle after the next edge, then advance
  task automatic step(input logic [6:0] exp, input string req);
    item_t it;
    it.due = cyc + 1;
    it.exp = exp;
    it.req = req;
    sb_q.push_back(it);
    @(negedge clk);
  endtask

  // monitor
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due == cyc) begin
      item_t it;
      logic [6:0] act;
      it = sb_q.pop_front();
      act = {ctrl_bits, cpu_en, per_en, osc_en, resume, restart};
      checks++;
      if (act !== it.exp) begin
        errors++;
        $display("FAIL %s cycle %0d actual %b expected %b", it.req, cyc, act, it.exp);
      end
    end
  end

  localparam logic [6:0] RUN0 = 7'b00_111_00;

  initial begin
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    step(RUN0, "R1");
    step(RUN0, "R1");

    // idle entry
    pcon_wr = 1'b1; pcon_wdata = 2'b01;
    step(ev(2'b01, 0, 1, 1, 0, 0), "R2");
    pcon_wr = 1'b0;
    step(ev(2'b01, 0, 1, 1, 0, 0), "R2");
    // write ignored in idle
    pcon_wr = 1'b1; pcon_wdata = 2'b10;
    step(ev(2'b01, 0, 1, 1, 0, 0), "R10");
    pcon_wr = 1'b0;
    // interrupt exit
    irq_pend = 8'h20;
    step(ev(2'b00, 1, 1, 1, 1, 0), "R4");
    irq_pend = '0;
    step(RUN0, "R4");

    // power-down with both bits set
    pcon_wr = 1'b1; pcon_wdata = 2'b11;
    step(ev(2'b11, 0, 0, 0, 0, 0), "R3");
    pcon_wr = 1'b0;
    irq_pend = 8'hFF;
    step(ev(2'b11, 0, 0, 0, 0, 0), "R9");
    irq_pend = '0;
    // external line without enable
    wake_en = 1'b0; ext_irq = 2'b01;
    step(ev(2'b11, 0, 0, 0, 0, 0), "R6");
    step(ev(2'b11, 0, 0, 0, 0, 0), "R6");
    // aborted settle
    wake_en = 1'b1;
    step(ev(2'b11, 0, 0, 1, 0, 0), "R8");
    step(ev(2'b11, 0, 0, 1, 0, 0), "R8");
    ext_irq = '0;
    step(ev(2'b11, 0, 0, 0, 0, 0), "R8");
    // full settle with count 3
    ext_irq = 2'b10;
    for (int i = 0; i < 4; i++) step(ev(2'b11, 0, 0, 1, 0, 0), "R7");
    step(ev(2'b00, 1, 1, 1, 1, 0), "R7");
    ext_irq = '0; wake_en = 1'b0;
    step(RUN0, "R7");

    // reset beats interrupt in idle
    pcon_wr = 1'b1; pcon_wdata = 2'b01;
    step(ev(2'b01, 0, 1, 1, 0, 0), "R2");
    pcon_wr = 1'b0;
    hw_rst = 1'b1; irq_pend = 8'h01;
    step(ev(2'b00, 1, 1, 1, 0, 1), "R5");
    hw_rst = 1'b0; irq_pend = '0;
    step(RUN0, "R5");

    // reset exit from power-down
    pcon_wr = 1'b1; pcon_wdata = 2'b10;
    step(ev(2'b10, 0, 0, 0, 0, 0), "R3");
    pcon_wr = 1'b0;
    hw_rst = 1'b1;
    for (int i = 0; i < 4; i++) step(ev(2'b10, 0, 0, 1, 0, 0), "R5");
    step(ev(2'b00, 1, 1, 1, 0, 1), "R5");
    hw_rst = 1'b0;
    step(RUN0, "R5");

    // settle count 0
    settle = 8'd0;
    pcon_wr = 1'b1; pcon_wdata = 2'b10;
    step(ev(2'b10, 0, 0, 0, 0, 0), "R3");
    pcon_wr = 1'b0;
    wake_en = 1'b1; ext_irq = 2'b01;
    step(ev(2'b10, 0, 0, 1, 0, 0), "R7");
    step(ev(2'b00, 1, 1, 1, 1, 0), "R7");
    ext_irq = '0;
    step(RUN0, "R7");

    @(negedge clk);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired actual running expected finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule